// File: doc/BRIEF.md
# Index Register Bank with Effective-Address Adder

This block keeps the index registers of a small 16-bit processor and forms operand addresses from the instruction word. Four slots are addressed by instruction bits 9..8. Slot 0 is a constant zero, so an instruction that selects slot 0 gets plain direct addressing with no special path in the control logic. Slots 1 to 3 are writable.

The address field is the low byte of the instruction, zero-extended to 16 bits. When the top instruction bit is clear, the selected slot is added to the field. When that bit is set, indexing is suppressed and the field alone is the address. A 2-bit operation code loads a slot from the result bus, increments it or decrements it. The selected slot can be driven onto an operand bus. A zero flag and a branch-decision output serve increment-and-test and decrement-and-test branches.

There is no state machine. The only sequential state is the slot storage and a one-bit record of the direction of the last step. Both are written at the rising clock edge, and every output is combinational from that state and the current inputs.

Top module: `idx_addr_unit`

## Requirements
- R1: A synchronous active-high reset clears slots 1 to 3 to zero and sets the remembered step direction to "increment".
- R2: Slot 0 (selector 00) always reads zero. Load, increment and decrement operations aimed at it have no effect.
- R3: Operation code 01 stores `res_bus` into the selected slot at the rising edge. `opnd_bus` shows the selected slot while `opnd_rd` is 1 and shows zero while it is 0.
- R4: When `ir[15]` is 0, `eff_addr` equals `{8'h00, ir[7:0]}` plus the selected slot, modulo 2^16 (the carry out of bit 15 is dropped).
- R5: When `ir[15]` is 1, `eff_addr` equals `{8'h00, ir[7:0]}`, whatever the selected slot holds.
- R6: Operation code 10 adds one to the selected slot and code 11 subtracts one, both wrapping modulo 2^16. Code 00 leaves every slot unchanged.
- R7: `sel_zero` is 1 exactly when the slot selected by `ir[9:8]` holds zero. The flag is combinational, so it reflects a step in the cycle after that step.
- R8: `br_take` equals `sel_zero` if the most recent increment or decrement operation (codes 10/11) was an increment. It equals the inverse of `sel_zero` if that operation was a decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 16 | Instruction word: bit 15 suppresses indexing, bits 9..8 select the slot, bits 7..0 are the address field |
| ix_op | input | 2 | 00 hold, 01 load from `res_bus`, 10 increment, 11 decrement |
| res_bus | input | 16 | Result-bus data used for loads |
| opnd_rd | input | 1 | Drives the selected slot onto `opnd_bus` |
| opnd_bus | output | 16 | Selected slot when `opnd_rd` is 1, else zero |
| eff_addr | output | 16 | Effective address |
| sel_zero | output | 1 | Selected slot equals zero |
| br_take | output | 1 | Branch decision for increment/decrement-and-test |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit address field and four slots. At this width the wrap points are easy to reach. The bench steps 0xFFFF up to zero and steps zero down to 0xFFFF, and it adds a field of 0xFF to a slot near the top of the range so that the address carry is dropped. Both branch senses are exercised, each on a zero and on a non-zero slot. A reset in the middle of the run checks that the remembered direction and the register contents return to their reset values.

// File: rtl/idx_pkg.sv
package idx_pkg;
    typedef enum logic [1:0] {
        IX_HOLD = 2'b00,
        IX_LOAD = 2'b01,
        IX_INC  = 2'b10,
        IX_DEC  = 2'b11
    } ix_op_e;
endpackage

// File: rtl/idx_slot_bank.sv
module idx_slot_bank #(
    parameter int DATA_W    = 16,
    parameter int NUM_SLOTS = 4,
    localparam int SEL_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        if (s == 0) begin : g_const
            // constant-zero slot: no storage, writes have nowhere to go
            assign slot_q[s] = '0;
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[s] <= '0;
                else if (wr_en && sel == SEL_W'(s))
                    slot_q[s] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[sel];
endmodule

// File: rtl/idx_ea_adder.sv
module idx_ea_adder #(
    parameter int DATA_W  = 16,
    parameter int FIELD_W = 8
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [DATA_W-1:0]  idx_val,
    input  logic               no_index,
    output logic [DATA_W-1:0]  ea
);
    localparam int PAD_W = DATA_W - FIELD_W;

    logic [DATA_W-1:0] field_ext;
    logic [DATA_W-1:0] addend;

    assign field_ext = {{PAD_W{1'b0}}, field};
    assign addend    = no_index ? '0 : idx_val;
    assign ea        = field_ext + addend;  // carry out is dropped by width
endmodule

// File: rtl/idx_step_ctrl.sv
module idx_step_ctrl
    import idx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ix_op_e            op,
    input  logic [DATA_W-1:0] res_bus,
    input  logic [DATA_W-1:0] cur_val,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              is_zero,
    output logic              br_take
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic dir_up_q;

    always_comb begin
        wr_en   = 1'b1;
        wr_data = cur_val;
        unique case (op)
            IX_HOLD: wr_en   = 1'b0;
            IX_LOAD: wr_data = res_bus;
            IX_INC:  wr_data = cur_val + ONE;
            IX_DEC:  wr_data = cur_val - ONE;
            default: wr_en   = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            dir_up_q <= 1'b1;
        else if (op == IX_INC)
            dir_up_q <= 1'b1;
        else if (op == IX_DEC)
            dir_up_q <= 1'b0;
    end

    assign is_zero = (cur_val == '0);
    assign br_take = dir_up_q ? is_zero : ~is_zero;
endmodule

// File: rtl/idx_addr_unit.sv
module idx_addr_unit
    import idx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FIELD_W   = 8,
    parameter int NUM_SLOTS = 4,
    parameter int SEL_LSB   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ir,
    input  logic [1:0]        ix_op,
    input  logic [DATA_W-1:0] res_bus,
    input  logic              opnd_rd,
    output logic [DATA_W-1:0] opnd_bus,
    output logic [DATA_W-1:0] eff_addr,
    output logic              sel_zero,
    output logic              br_take
);
    localparam int SEL_W   = $clog2(NUM_SLOTS);
    localparam int NOIX_BIT = DATA_W - 1;

    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] cur_val;
    logic [DATA_W-1:0] wr_data;
    logic              wr_en;
    ix_op_e            op;

    assign sel = ir[SEL_LSB +: SEL_W];
    assign op  = ix_op_e'(ix_op);

    idx_slot_bank #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .rd_data (cur_val)
    );

    idx_step_ctrl #(.DATA_W(DATA_W)) u_step (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .res_bus (res_bus),
        .cur_val (cur_val),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .is_zero (sel_zero),
        .br_take (br_take)
    );

    idx_ea_adder #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_ea (
        .field    (ir[FIELD_W-1:0]),
        .idx_val  (cur_val),
        .no_index (ir[NOIX_BIT]),
        .ea       (eff_addr)
    );

    assign opnd_bus = opnd_rd ? cur_val : '0;
endmodule

// File: rtl/idx_addr_unit_chk.sv
module idx_addr_unit_chk #(
    parameter int DATA_W    = 16,
    parameter int FIELD_W   = 8,
    parameter int NUM_SLOTS = 4,
    parameter int SEL_LSB   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] ir,
    input logic [1:0]        ix_op,
    input logic [DATA_W-1:0] res_bus,
    input logic              opnd_rd,
    input logic [DATA_W-1:0] opnd_bus,
    input logic [DATA_W-1:0] eff_addr,
    input logic              sel_zero,
    input logic              br_take
);
    localparam int SEL_W = $clog2(NUM_SLOTS);
    localparam int PAD_W = DATA_W - FIELD_W;

    logic [SEL_W-1:0] sel;
    assign sel = ir[SEL_LSB +: SEL_W];

    // R2: selector zero always reports a zero slot
    p_slot0_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (sel_zero && opnd_bus == '0));

    // R3: a load shows up on the operand bus in the next cycle
    p_load_visible_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ix_op) == 2'b01 && $past(sel) != '0
         && sel == $past(sel) && opnd_rd)
        |-> opnd_bus == $past(res_bus));

    // R3: operand bus idles at zero
    p_bus_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !opnd_rd |-> opnd_bus == '0);

    // R4: indexed address matches field plus the driven operand
    p_ea_indexed_r4: assert property (@(posedge clk) disable iff (rst)
        (!ir[DATA_W-1] && opnd_rd)
        |-> eff_addr == DATA_W'({{PAD_W{1'b0}}, ir[FIELD_W-1:0]} + opnd_bus));

    // R5: indexing suppressed
    p_ea_direct_r5: assert property (@(posedge clk) disable iff (rst)
        ir[DATA_W-1] |-> eff_addr == {{PAD_W{1'b0}}, ir[FIELD_W-1:0]});

    // R6: increment step
    p_inc_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ix_op) == 2'b10 && $past(opnd_rd) && opnd_rd
         && sel == $past(sel) && sel != '0)
        |-> opnd_bus == DATA_W'($past(opnd_bus) + DATA_W'(1)));

    // R6: decrement step
    p_dec_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ix_op) == 2'b11 && $past(opnd_rd) && opnd_rd
         && sel == $past(sel) && sel != '0)
        |-> opnd_bus == DATA_W'($past(opnd_bus) - DATA_W'(1)));

    // R7: zero flag agrees with the driven operand
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
        opnd_rd |-> sel_zero == (opnd_bus == '0));

    // R8: branch sense follows the last step direction
    p_br_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ix_op) == 2'b10) |-> br_take == sel_zero);

    p_br_dec_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ix_op) == 2'b11) |-> br_take == !sel_zero);

    // R1: registers and direction are back at their reset values
    p_after_reset_r1: assert property (@(posedge clk)
        ($past(rst) && !rst && opnd_rd) |-> (opnd_bus == '0 && br_take));
endmodule

bind idx_addr_unit idx_addr_unit_chk #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .NUM_SLOTS(NUM_SLOTS), .SEL_LSB(SEL_LSB)
) u_chk (
    .clk(clk), .rst(rst), .ir(ir), .ix_op(ix_op), .res_bus(res_bus),
    .opnd_rd(opnd_rd), .opnd_bus(opnd_bus), .eff_addr(eff_addr),
    .sel_zero(sel_zero), .br_take(br_take)
);

// File: tb/test_idx_addr_unit.sv
module test_idx_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ir = '0;
    logic [1:0]  ix_op = 2'b00;
    logic [15:0] res_bus = '0;
    logic        opnd_rd = 1'b0;
    logic [15:0] opnd_bus, eff_addr;
    logic        sel_zero, br_take;

    always #10 clk = ~clk;

    idx_addr_unit i_idx_addr_unit (
        .clk(clk), .rst(rst), .ir(ir), .ix_op(ix_op), .res_bus(res_bus),
        .opnd_rd(opnd_rd), .opnd_bus(opnd_bus), .eff_addr(eff_addr),
        .sel_zero(sel_zero), .br_take(br_take)
    );

    typedef struct {
        logic [15:0] bus;
        logic [15:0] ea;
        logic        z;
        logic        br;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_vec  = 0;
    int          n_fail = 0;
    logic [15:0] m_slot [4];
    logic        m_up;
    bit          done = 0;

    function automatic logic [15:0] mk_ir(logic noix, logic [1:0] s, logic [7:0] f);
        return {noix, 5'b00000, s, f};
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) m_slot[k] = '0;
        m_up = 1'b1;
    endtask

    task automatic drive(logic [15:0] i_ir, logic [1:0] op, logic [15:0] d,
                         logic rd, string tag);
        exp_t        e;
        logic [1:0]  s;
        logic [15:0] v;
        @(negedge clk);
        rst = 1'b0; ir = i_ir; ix_op = op; res_bus = d; opnd_rd = rd;
        s = i_ir[9:8];
        v = (s == 2'd0) ? 16'h0 : m_slot[s];
        e.bus = rd ? v : 16'h0;
        e.ea  = i_ir[15] ? {8'h00, i_ir[7:0]} : 16'({8'h00, i_ir[7:0]} + v);
        e.z   = (v == 16'h0);
        e.br  = m_up ? e.z : !e.z;
        e.tag = tag;
        sb_q.push_back(e);
        if (s != 2'd0) begin
            case (op)
                2'b01: m_slot[s] = d;
                2'b10: m_slot[s] = v + 16'h1;
                2'b11: m_slot[s] = v - 16'h1;
                default: ;
            endcase
        end
        if (op == 2'b10) m_up = 1'b1;
        if (op == 2'b11) m_up = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ix_op = 2'b00; opnd_rd = 1'b0;
        @(negedge clk);
        model_reset();
    endtask

    // monitor: compare mid-low-phase, well away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (opnd_bus !== e.bus || eff_addr !== e.ea ||
                    sel_zero !== e.z || br_take !== e.br) begin
                    n_fail++;
                    $display("FAIL %s: bus=%h ea=%h z=%b br=%b expected bus=%h ea=%h z=%b br=%b",
                             e.tag, opnd_bus, eff_addr, sel_zero, br_take,
                             e.bus, e.ea, e.z, e.br);
                end
            end
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1: all slots clear after reset
        drive(mk_ir(1, 2'd1, 8'h00), 2'b00, 16'h0, 1, "R1");
        drive(mk_ir(1, 2'd2, 8'h00), 2'b00, 16'h0, 1, "R1");
        drive(mk_ir(1, 2'd3, 8'h00), 2'b00, 16'h0, 1, "R1");
        // R3: loads, then visibility gated by opnd_rd
        drive(mk_ir(1, 2'd1, 8'h00), 2'b01, 16'h1234, 0, "R3");
        drive(mk_ir(1, 2'd2, 8'h00), 2'b01, 16'h00F0, 0, "R3");
        drive(mk_ir(1, 2'd3, 8'h00), 2'b01, 16'hFFF0, 0, "R3");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b00, 16'h0, 1, "R3");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b00, 16'h0, 0, "R3");
        // R2: slot 0 ignores load and steps
        drive(mk_ir(1, 2'd0, 8'h00), 2'b01, 16'hBEEF, 1, "R2");
        drive(mk_ir(1, 2'd0, 8'h00), 2'b11, 16'h0, 1, "R2");
        drive(mk_ir(1, 2'd0, 8'h00), 2'b00, 16'h0, 1, "R2");
        // R4: indexed addressing, including dropped carry and slot 0
        drive(mk_ir(0, 2'd1, 8'h05), 2'b00, 16'h0, 1, "R4");
        drive(mk_ir(0, 2'd3, 8'hFF), 2'b00, 16'h0, 0, "R4");
        drive(mk_ir(0, 2'd0, 8'h42), 2'b00, 16'h0, 1, "R4");
        // R5: indexing suppressed
        drive(mk_ir(1, 2'd2, 8'h80), 2'b00, 16'h0, 1, "R5");
        drive(mk_ir(1, 2'd3, 8'hFF), 2'b00, 16'h0, 0, "R5");
        // R6: steps and hold
        drive(mk_ir(1, 2'd2, 8'h00), 2'b10, 16'h0, 1, "R6");
        drive(mk_ir(1, 2'd2, 8'h00), 2'b00, 16'h0, 1, "R6");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b11, 16'h0, 1, "R6");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b11, 16'h0, 1, "R6");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b00, 16'hAAAA, 1, "R6");
        // R6/R7/R8: wrap up to zero, branch on zero after increment
        drive(mk_ir(1, 2'd3, 8'h00), 2'b01, 16'hFFFF, 1, "R6");
        drive(mk_ir(1, 2'd3, 8'h00), 2'b10, 16'h0, 1, "R8");
        drive(mk_ir(1, 2'd3, 8'h00), 2'b00, 16'h0, 1, "R7");
        drive(mk_ir(1, 2'd2, 8'h00), 2'b00, 16'h0, 1, "R8");
        // decrement wraps zero down, branch on non-zero after decrement
        drive(mk_ir(1, 2'd3, 8'h00), 2'b11, 16'h0, 1, "R6");
        drive(mk_ir(1, 2'd3, 8'h00), 2'b00, 16'h0, 1, "R8");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b01, 16'h0001, 1, "R3");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b11, 16'h0, 1, "R8");
        drive(mk_ir(1, 2'd1, 8'h00), 2'b00, 16'h0, 1, "R8");
        drive(mk_ir(0, 2'd1, 8'h10), 2'b00, 16'h0, 1, "R7");
        // R1: reset mid-run restores slots and direction
        do_reset();
        drive(mk_ir(1, 2'd2, 8'h00), 2'b00, 16'h0, 1, "R1");
        drive(mk_ir(0, 2'd3, 8'h33), 2'b00, 16'h0, 1, "R1");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule